// File: doc/BRIEF.md
# Two-Level Instruction Control Decoder

This block turns the opcode and function fields of a 32-bit instruction word into the control signals of a single-cycle datapath. It is purely combinational. Every output settles from the current inputs alone. The block holds no state, so it has no clock and no reset.

Decoding happens in two levels. A primary decoder looks only at the 6-bit opcode. It produces the datapath steering bits and a compact 3-bit operation class. A secondary decoder then turns that class into a 3-bit ALU operation code. It consults the 6-bit function field only when the class says "register-register".

The recognised instructions are:

- register-register arithmetic
- OR with an immediate
- word load
- word store
- branch-if-equal
- jump

Any other opcode yields a safe result that writes nothing and moves no control flow. Outputs that do not matter for an instruction are driven to 0, so the result for every input is fully determined.

Top module: `ctrl_decode_top`

## Requirements
- R1: Six opcodes are recognised: 000000 register-register, 001101 OR-immediate, 100011 load, 101011 store, 000100 branch-if-equal, 000010 jump.
- R2: `reg_we` is 1 for OR-immediate, for load, and for register-register with a recognised function code. It is 0 for store, branch and jump.
- R3: `dst_sel_rd` is 1 only for register-register (recognised or not) and 0 for every other opcode.
- R4: `src_sel_imm` is 1 for OR-immediate, load and store, and 0 for all other opcodes.
- R5: `wb_sel_mem` is 1 only for load, and `mem_we` is 1 only for store.
- R6: `is_branch` is 1 only for branch-if-equal, and `is_jump` is 1 only for jump.
- R7: `ext_sign` is 1 (sign extension) for load and store. It is 0 (zero extension) for OR-immediate and for all other opcodes.
- R8: `alu_class` is 100 for register-register, 010 for OR-immediate and 001 for branch-if-equal. It is 000 for load, store, jump and unknown opcodes.
- R9: With class 100, `alu_code` follows the function field as follows: 100000 gives 010 (add), 100010 gives 110 (subtract), 100100 gives 000 (and), 100101 gives 001 (or), and 101010 gives 111 (set-on-less-than).
- R10: With a class other than 100, the function field has no effect. Class 000 gives 010, class 010 gives 001 and class 001 gives 110.
- R11: An unrecognised opcode drives every output to 0 except `alu_code`, which is 010 (add).
- R12: A register-register opcode with an unrecognised function field gives `reg_we` 0 and `alu_code` 010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Primary operation field of the instruction |
| funct | input | 6 | Function field, consulted for register-register only |
| dst_sel_rd | output | 1 | Destination register from the third register field |
| src_sel_imm | output | 1 | Second ALU operand is the extended immediate |
| wb_sel_mem | output | 1 | Write-back data comes from data memory |
| reg_we | output | 1 | Register file write enable |
| mem_we | output | 1 | Data memory write enable |
| is_branch | output | 1 | Conditional branch on equality |
| is_jump | output | 1 | Unconditional jump |
| ext_sign | output | 1 | 1 sign-extends the immediate, 0 zero-extends it |
| alu_class | output | 3 | Operation class passed to the second level |
| alu_code | output | 3 | Final ALU operation code |

## Verification
The bench sweeps all 64 opcodes against a spread of function values. This catches a decoder that matches too few opcode bits, because a near neighbour of a valid opcode (for example 100001 next to load) would then write the register file. It also sweeps all 64 function values under the register-register opcode. That exposes any function bit left out of the match. In particular, subtract and set-on-less-than differ only in bit 3, so a careless match would produce the wrong ALU code. The function field is also varied under the non-register opcodes. A second level that peeks at it outside class 100 would change the ALU code for OR-immediate or branch.

// File: rtl/ctrl_decode_pkg.sv
package ctrl_decode_pkg;
    localparam int OPC_W  = 6;
    localparam int FN_W   = 6;
    localparam int CLS_W  = 3;
    localparam int CODE_W = 3;

    localparam logic [OPC_W-1:0] OPC_RR   = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_ORI  = 6'b001101;
    localparam logic [OPC_W-1:0] OPC_LOAD = 6'b100011;
    localparam logic [OPC_W-1:0] OPC_STOR = 6'b101011;
    localparam logic [OPC_W-1:0] OPC_BEQ  = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_JMP  = 6'b000010;

    localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
    localparam logic [FN_W-1:0] FN_SUB = 6'b100010;
    localparam logic [FN_W-1:0] FN_AND = 6'b100100;
    localparam logic [FN_W-1:0] FN_OR  = 6'b100101;
    localparam logic [FN_W-1:0] FN_SLT = 6'b101010;

    typedef enum logic [CLS_W-1:0] {
        CLS_ADD   = 3'b000,
        CLS_SUB   = 3'b001,
        CLS_OR    = 3'b010,
        CLS_FUNCT = 3'b100
    } alu_class_e;

    typedef enum logic [CODE_W-1:0] {
        OPX_AND = 3'b000,
        OPX_OR  = 3'b001,
        OPX_ADD = 3'b010,
        OPX_SUB = 3'b110,
        OPX_SLT = 3'b111
    } alu_code_e;

    typedef struct packed {
        logic       dst_sel_rd;
        logic       src_sel_imm;
        logic       wb_sel_mem;
        logic       reg_we;
        logic       mem_we;
        logic       is_branch;
        logic       is_jump;
        logic       ext_sign;
        alu_class_e alu_class;
    } main_ctrl_t;
endpackage

// File: rtl/ctrl_main_dec.sv
module ctrl_main_dec
    import ctrl_decode_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output main_ctrl_t       ctrl
);
    always_comb begin
        ctrl = '{default: '0, alu_class: CLS_ADD};
        case (opcode)
            OPC_RR: begin
                ctrl.dst_sel_rd = 1'b1;
                ctrl.reg_we     = 1'b1;
                ctrl.alu_class  = CLS_FUNCT;
            end
            OPC_ORI: begin
                ctrl.src_sel_imm = 1'b1;
                ctrl.reg_we      = 1'b1;
                ctrl.alu_class   = CLS_OR;
            end
            OPC_LOAD: begin
                ctrl.src_sel_imm = 1'b1;
                ctrl.wb_sel_mem  = 1'b1;
                ctrl.reg_we      = 1'b1;
                ctrl.ext_sign    = 1'b1;
            end
            OPC_STOR: begin
                ctrl.src_sel_imm = 1'b1;
                ctrl.mem_we      = 1'b1;
                ctrl.ext_sign    = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.is_branch = 1'b1;
                ctrl.alu_class = CLS_SUB;
            end
            OPC_JMP: ctrl.is_jump = 1'b1;
            default: ;
        endcase

        // R6
        one_effect_chk: assert ($onehot0({ctrl.reg_we, ctrl.mem_we, ctrl.is_branch, ctrl.is_jump}))
            else $error("more than one state-changing effect");
        // R5
        wb_mem_we_chk: assert (!ctrl.wb_sel_mem || ctrl.reg_we)
            else $error("memory write-back without register write");
        // R7
        ext_imm_chk: assert (!ctrl.ext_sign || ctrl.src_sel_imm)
            else $error("sign extension without immediate operand");
    end
endmodule

// File: rtl/ctrl_alu_dec.sv
module ctrl_alu_dec
    import ctrl_decode_pkg::*;
(
    input  alu_class_e      alu_class,
    input  logic [FN_W-1:0] funct,
    output alu_code_e       alu_code,
    output logic            funct_ok
);
    always_comb begin
        alu_code = OPX_ADD;
        funct_ok = 1'b1;
        case (alu_class)
            CLS_FUNCT: begin
                case (funct)
                    FN_ADD:  alu_code = OPX_ADD;
                    FN_SUB:  alu_code = OPX_SUB;
                    FN_AND:  alu_code = OPX_AND;
                    FN_OR:   alu_code = OPX_OR;
                    FN_SLT:  alu_code = OPX_SLT;
                    default: funct_ok = 1'b0;
                endcase
            end
            CLS_OR:  alu_code = OPX_OR;
            CLS_SUB: alu_code = OPX_SUB;
            default: alu_code = OPX_ADD;
        endcase

        // R9
        legal_code_chk: assert (alu_code != 3'b011 && alu_code != 3'b100 && alu_code != 3'b101)
            else $error("reserved ALU code produced");
        // R12
        bad_funct_add_chk: assert (funct_ok || alu_code == OPX_ADD)
            else $error("unrecognised function did not fall back to add");
    end
endmodule

// File: rtl/ctrl_decode_top.sv
module ctrl_decode_top
    import ctrl_decode_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output logic       dst_sel_rd,
    output logic       src_sel_imm,
    output logic       wb_sel_mem,
    output logic       reg_we,
    output logic       mem_we,
    output logic       is_branch,
    output logic       is_jump,
    output logic       ext_sign,
    output logic [2:0] alu_class,
    output logic [2:0] alu_code
);
    main_ctrl_t mc;
    alu_code_e  code_w;
    logic       fn_ok;

    ctrl_main_dec u_main (
        .opcode (opcode),
        .ctrl   (mc)
    );

    ctrl_alu_dec u_alu (
        .alu_class (mc.alu_class),
        .funct     (funct),
        .alu_code  (code_w),
        .funct_ok  (fn_ok)
    );

    always_comb begin
        dst_sel_rd  = mc.dst_sel_rd;
        src_sel_imm = mc.src_sel_imm;
        wb_sel_mem  = mc.wb_sel_mem;
        reg_we      = mc.reg_we & fn_ok;
        mem_we      = mc.mem_we;
        is_branch   = mc.is_branch;
        is_jump     = mc.is_jump;
        ext_sign    = mc.ext_sign;
        alu_class   = mc.alu_class;
        alu_code    = code_w;
    end
endmodule

// File: tb/ctrl_decode_top_tb.sv
module ctrl_decode_top_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [5:0] opcode, funct;
    logic dst_sel_rd, src_sel_imm, wb_sel_mem, reg_we, mem_we, is_branch, is_jump, ext_sign;
    logic [2:0] alu_class, alu_code;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    ctrl_decode_top u_dut (
        .opcode(opcode), .funct(funct),
        .dst_sel_rd(dst_sel_rd), .src_sel_imm(src_sel_imm), .wb_sel_mem(wb_sel_mem),
        .reg_we(reg_we), .mem_we(mem_we), .is_branch(is_branch), .is_jump(is_jump),
        .ext_sign(ext_sign), .alu_class(alu_class), .alu_code(alu_code)
    );

    task automatic chk(input string req, input string fld, input int got, input int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s op=%b fn=%b actual=%0d expected=%0d", req, fld, opcode, funct, got, exp);
        end
    endtask

    // behavioural reference derived from the requirement list
    task automatic apply(input int op, input int fn);
        int e_dst = 0, e_src = 0, e_wb = 0, e_we = 0, e_mwe = 0, e_br = 0, e_j = 0, e_ext = 0;
        int e_cls = 0, e_code = 2;
        @(negedge clk);
        opcode = 6'(op);
        funct  = 6'(fn);
        if (op == 0) begin
            e_dst = 1; e_cls = 4;
            if      (fn == 32) begin e_we = 1; e_code = 2; end
            else if (fn == 34) begin e_we = 1; e_code = 6; end
            else if (fn == 36) begin e_we = 1; e_code = 0; end
            else if (fn == 37) begin e_we = 1; e_code = 1; end
            else if (fn == 42) begin e_we = 1; e_code = 7; end
        end else if (op == 13) begin
            e_src = 1; e_we = 1; e_cls = 2; e_code = 1;
        end else if (op == 35) begin
            e_src = 1; e_wb = 1; e_we = 1; e_ext = 1;
        end else if (op == 43) begin
            e_src = 1; e_mwe = 1; e_ext = 1;
        end else if (op == 4) begin
            e_br = 1; e_cls = 1; e_code = 6;
        end else if (op == 2) begin
            e_j = 1;
        end
        #2;
        chk("R3",  "dst_sel_rd",  int'(dst_sel_rd),  e_dst);
        chk("R4",  "src_sel_imm", int'(src_sel_imm), e_src);
        chk("R5",  "wb_sel_mem",  int'(wb_sel_mem),  e_wb);
        chk("R2",  "reg_we",      int'(reg_we),      e_we);
        chk("R5",  "mem_we",      int'(mem_we),      e_mwe);
        chk("R6",  "is_branch",   int'(is_branch),   e_br);
        chk("R6",  "is_jump",     int'(is_jump),     e_j);
        chk("R7",  "ext_sign",    int'(ext_sign),    e_ext);
        chk("R8",  "alu_class",   int'(alu_class),   e_cls);
        chk((op == 0) ? "R9" : "R10", "alu_code", int'(alu_code), e_code);
    endtask

    initial begin
        opcode = '0;
        funct  = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // reset-time pattern: register-register with function 000000 (R12)
        apply(0, 0);
        // R1: each recognised opcode with a valid function
        apply(0, 32); apply(0, 34); apply(0, 36); apply(0, 37); apply(0, 42);
        apply(13, 0); apply(35, 0); apply(43, 0); apply(4, 0); apply(2, 0);
        // R9 / R12: all function values under register-register
        for (int f = 0; f < 64; f++) apply(0, f);
        // R10 / R11: all opcodes against a spread of function values
        for (int o = 0; o < 64; o++) begin
            apply(o, 0);  apply(o, 32); apply(o, 34); apply(o, 36);
            apply(o, 37); apply(o, 42); apply(o, 63); apply(o, 8);
        end
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                tests++;
                fails++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule